// File: doc/BRIEF.md
# SPI Byte FIFO Status and Interrupt Unit

This block sits between a host bus and an SPI shift engine. It holds a receive queue, filled by the engine and drained by the host, and a transmit queue, filled by the host and drained by the engine. Both queues are one byte wide and eight entries deep by default. It reports both fill levels as one packed byte, and a full flag and an empty flag for each queue.

The unit has six interrupt sources. Each has a sticky status bit and an enable bit. The sources are receive overrun, transmit underrun, receive level threshold, transmit level threshold, transfer completion and command reception. A status bit stays set until the host writes 1 to the matching clear bit. The single interrupt line is raised while any enabled status bit is set.

Three one-cycle strobes cover reset. Flushing the receive queue or the transmit queue empties only that queue. A soft reset empties both queues, clears every status bit and restores the threshold. The shift engine is modelled by push, pop, done and command strobes.

Top module: `spi_fifo_irq`

## Requirements
- R1: While `rst_n` is low, both counts read 0, both empty flags are 1, both full flags are 0, all status bits are 0 and `irq` is 0. The threshold resets to 4.
- R2: `fill_cnt[3:0]` holds the receive count and `fill_cnt[7:4]` holds the transmit count, each updated on the edge that accepts a push or pop. Bytes leave each queue in the order they entered.
- R3: A full flag is 1 exactly when its count equals the depth (8). An empty flag is 1 exactly when its count is 0. A count never exceeds the depth.
- R4: An engine push while the receive queue is full and no host pop occurs is dropped. The count and contents stay unchanged, and status bit 0 (receive overrun) is set on that edge.
- R5: An engine pop while the transmit queue is empty returns `e_tx_data` = 0x00 in that cycle and sets status bit 1 (transmit underrun) on that edge.
- R6: Status bit 2 is set one edge after the receive count is at or above the threshold.
- R7: Status bit 3 is set one edge after the transmit count is at or below the threshold.
- R8: `e_done` sets status bit 4 and `e_cmd` sets status bit 5, each on the edge that samples the strobe.
- R9: A 1 in `sts_clr` clears that status bit on the next edge, unless the bit's set condition is true in the same cycle. A 0 in `sts_clr` leaves the bit alone, and set bits stay set.
- R10: `irq` is 1 exactly when some bit of `irq_sts & irq_en` is 1, and it follows a change of `irq_en` with no clock.
- R11: `rx_flush` empties only the receive queue and `tx_flush` empties only the transmit queue, on the edge that samples the strobe.
- R12: `soft_rst` empties both queues, clears every status bit and restores the threshold to 4, all on one edge.
- R13: `cfg_thr_we` loads `cfg_thr` (3 bits) as the new threshold for both level comparisons.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_thr_we | input | 1 | Load strobe for the threshold |
| cfg_thr | input | 3 | New threshold value |
| soft_rst | input | 1 | Soft reset pulse |
| rx_flush | input | 1 | Empty the receive queue |
| tx_flush | input | 1 | Empty the transmit queue |
| irq_en | input | 6 | Per-source interrupt enables |
| sts_clr | input | 6 | Write-1-to-clear pulses for the status bits |
| h_tx_push | input | 1 | Host writes a byte into the transmit queue |
| h_tx_data | input | 8 | Byte written by the host |
| h_rx_pop | input | 1 | Host takes a byte from the receive queue |
| h_rx_data | output | 8 | Head of the receive queue (0 when empty) |
| e_rx_push | input | 1 | Engine delivers a received byte |
| e_rx_data | input | 8 | Received byte |
| e_tx_pop | input | 1 | Engine takes a byte to send |
| e_tx_data | output | 8 | Head of the transmit queue (0 when empty) |
| e_done | input | 1 | Transfer-complete strobe |
| e_cmd | input | 1 | Command-byte-received strobe |
| fill_cnt | output | 8 | Transmit count (high nibble), receive count (low nibble) |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| irq_sts | output | 6 | Sticky status bits |
| irq | output | 1 | Combined interrupt |

## Verification
The threshold bits are the hardest to observe at their crossing. Both are level-set, so a bit that is already set hides when its condition becomes true. The stimulus therefore first clears the bit while its condition is false and checks that it reads 0. It then moves the count across the boundary one entry at a time, checking the cycle just before the bit rises and the cycle it rises. Overrun likewise needs the receive queue filled to exactly its depth, and the stored contents are checked afterwards to confirm that the extra byte was dropped.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
    localparam int NSRC        = 6;
    localparam int SRC_RX_OVR  = 0;
    localparam int SRC_TX_UND  = 1;
    localparam int SRC_RX_THR  = 2;
    localparam int SRC_TX_THR  = 3;
    localparam int SRC_DONE    = 4;
    localparam int SRC_CMD     = 5;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          push_drop,
    output logic          pop_miss
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign full      = (cnt_q == CW'(DEPTH));
    assign empty     = (cnt_q == '0);
    assign do_pop    = pop && !empty;
    assign do_push   = push && (!full || do_pop);
    assign push_drop = push && !do_push;
    assign pop_miss  = pop && empty;
    assign rdata     = empty ? '0 : mem[rd_ptr];
    assign count     = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= wdata;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH)); // R3
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (cnt_q == CW'(DEPTH))); // R4
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
    import spi_fifo_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            srst,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    input  logic [NSRC-1:0] en_i,
    output logic [NSRC-1:0] sts_o,
    output logic            irq_o
);
    logic [NSRC-1:0] sts_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       sts_q[i] <= 1'b0;
            else if (srst)    sts_q[i] <= 1'b0;
            else              sts_q[i] <= (sts_q[i] && !clr_i[i]) || set_i[i];
        end
    end

    assign sts_o = sts_q;
    assign irq_o = |(sts_q & en_i);

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !srst |=> (($past(sts_q) & ~$past(clr_i) & ~sts_q) == '0)); // R9
endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int DW      = 8,
    parameter int TW      = 3,
    parameter int THR_RST = 4,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_thr_we,
    input  logic [TW-1:0]   cfg_thr,
    input  logic            soft_rst,
    input  logic            rx_flush,
    input  logic            tx_flush,
    input  logic [NSRC-1:0] irq_en,
    input  logic [NSRC-1:0] sts_clr,
    input  logic            h_tx_push,
    input  logic [DW-1:0]   h_tx_data,
    input  logic            h_rx_pop,
    output logic [DW-1:0]   h_rx_data,
    input  logic            e_rx_push,
    input  logic [DW-1:0]   e_rx_data,
    input  logic            e_tx_pop,
    output logic [DW-1:0]   e_tx_data,
    input  logic            e_done,
    input  logic            e_cmd,
    output logic [2*CW-1:0] fill_cnt,
    output logic            rx_full,
    output logic            rx_empty,
    output logic            tx_full,
    output logic            tx_empty,
    output logic [NSRC-1:0] irq_sts,
    output logic            irq
);
    logic [TW-1:0]   thr_q;
    logic [CW-1:0]   rx_cnt, tx_cnt;
    logic            rx_drop, rx_miss_unused, tx_drop_unused, tx_miss;
    logic [NSRC-1:0] set_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          thr_q <= TW'(THR_RST);
        else if (soft_rst)   thr_q <= TW'(THR_RST);
        else if (cfg_thr_we) thr_q <= cfg_thr;
    end

    spi_byte_fifo #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_rx (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush || soft_rst),
        .push(e_rx_push), .wdata(e_rx_data), .pop(h_rx_pop), .rdata(h_rx_data),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty),
        .push_drop(rx_drop), .pop_miss(rx_miss_unused));

    spi_byte_fifo #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_tx (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush || soft_rst),
        .push(h_tx_push), .wdata(h_tx_data), .pop(e_tx_pop), .rdata(e_tx_data),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty),
        .push_drop(tx_drop_unused), .pop_miss(tx_miss));

    always_comb begin
        set_vec             = '0;
        set_vec[SRC_RX_OVR] = rx_drop;
        set_vec[SRC_TX_UND] = tx_miss;
        set_vec[SRC_RX_THR] = (rx_cnt >= CW'(thr_q));
        set_vec[SRC_TX_THR] = (tx_cnt <= CW'(thr_q));
        set_vec[SRC_DONE]   = e_done;
        set_vec[SRC_CMD]    = e_cmd;
    end

    spi_irq_ctrl u_irq (
        .clk(clk), .rst_n(rst_n), .srst(soft_rst),
        .set_i(set_vec), .clr_i(sts_clr), .en_i(irq_en),
        .sts_o(irq_sts), .irq_o(irq));

    assign fill_cnt = {tx_cnt, rx_cnt};

    AST_UNDERRUN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (e_tx_pop && tx_empty) |-> (e_tx_data == '0)); // R5
    AST_UNDERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (e_tx_pop && tx_empty && !soft_rst) |=> irq_sts[SRC_TX_UND]); // R5
    AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (e_rx_push && rx_full && !h_rx_pop && !soft_rst) |=> irq_sts[SRC_RX_OVR]); // R4
    AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (e_done && !soft_rst) |=> irq_sts[SRC_DONE]); // R8
endmodule

// File: tb/test_spi_fifo_irq.sv
`timescale 1ns/1ps
module test_spi_fifo_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_thr_we = 0, soft_rst = 0, rx_flush = 0, tx_flush = 0;
    logic [2:0] cfg_thr = '0;
    logic [5:0] irq_en = '0, sts_clr = '0;
    logic       h_tx_push = 0, h_rx_pop = 0, e_rx_push = 0, e_tx_pop = 0, e_done = 0, e_cmd = 0;
    logic [7:0] h_tx_data = '0, e_rx_data = '0;
    logic [7:0] h_rx_data, e_tx_data, fill_cnt;
    logic       rx_full, rx_empty, tx_full, tx_empty, irq;
    logic [5:0] irq_sts;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    spi_fifo_irq i_spi_fifo_irq (
        .clk(clk), .rst_n(rst_n), .cfg_thr_we(cfg_thr_we), .cfg_thr(cfg_thr),
        .soft_rst(soft_rst), .rx_flush(rx_flush), .tx_flush(tx_flush),
        .irq_en(irq_en), .sts_clr(sts_clr),
        .h_tx_push(h_tx_push), .h_tx_data(h_tx_data), .h_rx_pop(h_rx_pop), .h_rx_data(h_rx_data),
        .e_rx_push(e_rx_push), .e_rx_data(e_rx_data), .e_tx_pop(e_tx_pop), .e_tx_data(e_tx_data),
        .e_done(e_done), .e_cmd(e_cmd), .fill_cnt(fill_cnt),
        .rx_full(rx_full), .rx_empty(rx_empty), .tx_full(tx_full), .tx_empty(tx_empty),
        .irq_sts(irq_sts), .irq(irq));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        cfg_thr_we = 0; soft_rst = 0; rx_flush = 0; tx_flush = 0; sts_clr = '0;
        h_tx_push = 0; h_rx_pop = 0; e_rx_push = 0; e_tx_pop = 0; e_done = 0; e_cmd = 0;
    endtask

    task automatic clear_bits(input logic [5:0] m);
        sts_clr = m;
        tick();
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1;
        chk("R1 counts", fill_cnt, 8'h00);
        chk("R1 flags", {rx_full, rx_empty, tx_full, tx_empty}, 4'b0101);
        chk("R1 status", irq_sts, 6'h00);
        chk("R1 irq", irq, 1'b0);
        rst_n = 1'b1;
        tick();
        chk("R7 tx level at reset", irq_sts[3], 1'b1);
        chk("R1 threshold 4: rx level 0", irq_sts[2], 1'b0);
    endtask

    task automatic t_events();
        e_done = 1; tick();
        chk("R8 done", irq_sts[4], 1'b1);
        e_cmd = 1; tick();
        chk("R8 cmd", irq_sts[5], 1'b1);
        chk("R10 masked", irq, 1'b0);
        irq_en = 6'b010000; #1;
        chk("R10 enabled done", irq, 1'b1);
        clear_bits(6'b100000);
        chk("R9 cleared cmd", irq_sts[5], 1'b0);
        chk("R9 done kept", irq_sts[4], 1'b1);
        chk("R10 still on", irq, 1'b1);
        clear_bits(6'b010000);
        chk("R9 cleared done", irq_sts[4], 1'b0);
        chk("R10 off", irq, 1'b0);
        irq_en = 6'b001000; #1;
        chk("R10 tx level", irq, 1'b1);
        irq_en = '0;
    endtask

    task automatic t_tx();
        for (int i = 0; i < 6; i++) begin
            h_tx_push = 1; h_tx_data = 8'hA0 + 8'(i); tick();
        end
        chk("R2 tx count nibble", fill_cnt, 8'h60);
        chk("R3 tx not empty", tx_empty, 1'b0);
        clear_bits(6'b001000);
        chk("R7 above thr clear", irq_sts[3], 1'b0);
        e_tx_pop = 1; #1; chk("R2 tx order 0", e_tx_data, 8'hA0); tick();
        e_tx_pop = 1; #1; chk("R2 tx order 1", e_tx_data, 8'hA1); tick();
        chk("R7 not yet", irq_sts[3], 1'b0);
        tick();
        chk("R7 at thr", irq_sts[3], 1'b1);
        for (int i = 2; i < 6; i++) begin
            e_tx_pop = 1; #1; chk("R2 tx order", e_tx_data, 8'hA0 + 8'(i)); tick();
        end
        chk("R3 tx empty", tx_empty, 1'b1);
        e_tx_pop = 1; #1;
        chk("R5 underrun data", e_tx_data, 8'h00);
        tick();
        chk("R5 underrun flag", irq_sts[1], 1'b1);
    endtask

    task automatic t_rx();
        clear_bits(6'b000111);
        for (int i = 0; i < 8; i++) begin
            e_rx_push = 1; e_rx_data = 8'hB0 + 8'(i); tick();
        end
        tick();
        chk("R3 rx full", rx_full, 1'b1);
        chk("R2 rx count nibble", fill_cnt[3:0], 4'd8);
        chk("R6 rx level", irq_sts[2], 1'b1);
        chk("R4 no overrun yet", irq_sts[0], 1'b0);
        e_rx_push = 1; e_rx_data = 8'hEE; tick();
        chk("R4 overrun flag", irq_sts[0], 1'b1);
        chk("R4 count kept", fill_cnt[3:0], 4'd8);
        for (int i = 0; i < 8; i++) begin
            h_rx_pop = 1; #1; chk("R4 R2 rx order", h_rx_data, 8'hB0 + 8'(i)); tick();
        end
        chk("R3 rx empty", rx_empty, 1'b1);
    endtask

    task automatic t_thr_write();
        cfg_thr_we = 1; cfg_thr = 3'd5; tick();
        clear_bits(6'b000100);
        for (int i = 0; i < 4; i++) begin
            e_rx_push = 1; e_rx_data = 8'(i); tick();
        end
        tick();
        chk("R13 below new thr", irq_sts[2], 1'b0);
        e_rx_push = 1; tick();
        chk("R6 just reached", irq_sts[2], 1'b0);
        tick();
        chk("R13 R6 at new thr", irq_sts[2], 1'b1);
    endtask

    task automatic t_flush();
        h_tx_push = 1; tick();
        h_tx_push = 1; tick();
        chk("R11 before", fill_cnt, 8'h25);
        rx_flush = 1; tick();
        chk("R11 rx flushed only", fill_cnt, 8'h20);
        tx_flush = 1; tick();
        chk("R11 tx flushed", fill_cnt, 8'h00);
    endtask

    task automatic t_soft();
        e_done = 1; tick();
        for (int i = 0; i < 3; i++) begin
            e_rx_push = 1; tick();
        end
        soft_rst = 1; tick();
        chk("R12 counts", fill_cnt, 8'h00);
        chk("R12 status", irq_sts, 6'h00);
        for (int i = 0; i < 4; i++) begin
            e_rx_push = 1; tick();
        end
        tick();
        chk("R12 thr back to 4", irq_sts[2], 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_events();
        t_tx();
        t_rx();
        t_thr_write();
        t_flush();
        t_soft();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule